// File: doc/BRIEF.md
# Thread Group Barrier Scheduler

This block sits beside the warp picker of a shader unit and decides, cycle by cycle, which warp slots may be issued. Warp slots are bound to thread groups at dispatch time. Each group is given a thread count, and the block turns that count into a number of 32-thread warps. From then on the block follows two things for every warp: whether it is parked at a barrier, and how many shared-memory and device-memory operations it still has in flight. Reads, texture fetches, unordered writes and atomics are all reported on the device-memory issue strobe.

A barrier names any mix of three components. The execution component holds every warp of the group until all of them have arrived. The shared-memory component waits until the group has no shared-memory operation pending. The device-memory component waits until the group has no device access pending. A warp is held until every component it names is satisfied. When an execution barrier releases, its arrival count is cleared, so the same group can reach its next barrier at once. The output is a per-warp runnable mask taken straight from registers.

Top module: `warp_barrier_sched`

## Requirements
- R1: After reset the runnable mask is all zero. A dispatch with thread count T and first slot F makes slots F to F+ceil(T/32)-1 runnable from the cycle after the dispatch edge.
- R2: A barrier accepted from a runnable warp makes that warp non-runnable from the next cycle. In the barrier kind, bit 0 is the execution component, bit 1 is the shared-memory component and bit 2 is the device-memory component.
- R3: Under an execution barrier, no warp of the group becomes runnable before the last warp of the group has arrived. All of them become runnable together on the second edge after the last arrival.
- R4: In a group of one warp, an execution-only barrier makes the warp non-runnable for exactly one cycle.
- R5: Releasing an execution barrier clears the group's arrival count, so a second barrier issued right away needs every warp again.
- R6: A shared-memory barrier holds until every shared-memory counter of the warp's own group is zero. Counters of other groups and device counters have no effect on it.
- R7: A device-memory barrier holds until every device counter of the group is zero. It ignores pending shared-memory operations.
- R8: A barrier with both the execution and device components releases only once all warps have arrived and the group's device counters are zero.
- R9: A shared or device issue and a completion for the same warp in the same cycle leave that warp's counter unchanged.
- R10: A 6-bit counter at 63 makes the warp non-runnable. A further issue is dropped rather than wrapping the counter.
- R11: Barriers without the execution component do not count as arrivals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Bind a run of warp slots to a group |
| disp_group | input | GID_W | Group being dispatched |
| disp_first | input | WID_W | First warp slot of the group |
| disp_threads | input | 11 | Threads in the group, 1 to 1024 |
| bar_valid | input | 1 | A warp issues a barrier |
| bar_warp | input | WID_W | Warp issuing the barrier |
| bar_kind | input | 3 | Barrier components: bit 0 execution, bit 1 shared, bit 2 device |
| shm_iss | input | NUM_WARPS | Per-warp shared-memory operation issued |
| shm_done | input | NUM_WARPS | Per-warp shared-memory operation completed |
| dev_iss | input | NUM_WARPS | Per-warp device access issued (read, texture, write, atomic) |
| dev_done | input | NUM_WARPS | Per-warp device access completed |
| runnable | output | NUM_WARPS | Warps the picker may issue |

## Verification
The bench runs the execution barrier in a four-warp group and checks the mask after each arrival. A design that released on a miscounted arrival total would free warps early. The single-warp group and the back-to-back barrier rounds catch an arrival count that is not cleared or that also counts memory-only barriers: in those cases a later round releases one warp too soon. Shared and device barriers are issued while the other kind of operation, or another group's operation, is still pending, which exposes a release condition that looks at the wrong counters. The last tests pair issue with completion in one cycle and drive a counter to its ceiling and beyond. A counter that drifts by one would strand a later barrier. A counter that wraps would bring the warp back to runnable too early.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
   localparam int unsigned WARP_THREADS = 32;
   localparam int unsigned THREAD_CNT_W = 11;

   typedef struct packed {
      logic dev;
      logic shm;
      logic exec;
   } bar_kind_t;
endpackage

// File: rtl/wbs_op_counter.sv
// Outstanding-operation counter for one warp and one memory class.
module wbs_op_counter #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             iss,
   input  logic             done,
   output logic [CNT_W-1:0] cnt,
   output logic             full
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic inc, dec;

   always_comb begin
      full = (cnt == CNT_MAX);
      // at the ceiling an issue only counts when a completion offsets it
      inc  = iss && (!full || done);
      dec  = done && ((cnt != '0) || inc);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (inc && !dec)
         cnt <= cnt + 1'b1;
      else if (dec && !inc)
         cnt <= cnt - 1'b1;
   end
endmodule

// File: rtl/wbs_group_sync.sv
// Arrival tracking and release decision for one thread group.
module wbs_group_sync
   import wbs_pkg::*;
#(
   parameter int unsigned WC_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [WC_W-1:0] load_cnt,
   input  logic            arrive,
   input  bar_kind_t       arrive_kind,
   input  logic            shm_idle,
   input  logic            dev_idle,
   output logic            go
);
   logic [WC_W-1:0] need_cnt;
   logic [WC_W-1:0] arr_cnt;
   logic            acc_shm, acc_dev;

   always_comb begin
      go = (need_cnt != '0) && (arr_cnt == need_cnt)
           && (!acc_shm || shm_idle) && (!acc_dev || dev_idle);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         need_cnt <= '0;
         arr_cnt  <= '0;
         acc_shm  <= 1'b0;
         acc_dev  <= 1'b0;
      end else if (load) begin
         need_cnt <= load_cnt;
         arr_cnt  <= '0;
         acc_shm  <= 1'b0;
         acc_dev  <= 1'b0;
      end else if (go) begin
         arr_cnt  <= '0;
         acc_shm  <= 1'b0;
         acc_dev  <= 1'b0;
      end else if (arrive) begin
         arr_cnt  <= arr_cnt + 1'b1;
         acc_shm  <= acc_shm | arrive_kind.shm;
         acc_dev  <= acc_dev | arrive_kind.dev;
      end
   end
endmodule

// File: rtl/warp_barrier_sched.sv
module warp_barrier_sched
   import wbs_pkg::*;
#(
   parameter int unsigned NUM_WARPS  = 8,
   parameter int unsigned NUM_GROUPS = 2,
   parameter int unsigned CNT_W      = 6,
   localparam int unsigned WID_W     = $clog2(NUM_WARPS),
   localparam int unsigned GID_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 disp_valid,
   input  logic [GID_W-1:0]     disp_group,
   input  logic [WID_W-1:0]     disp_first,
   input  logic [THREAD_CNT_W-1:0] disp_threads,
   input  logic                 bar_valid,
   input  logic [WID_W-1:0]     bar_warp,
   input  logic [2:0]           bar_kind,
   input  logic [NUM_WARPS-1:0] shm_iss,
   input  logic [NUM_WARPS-1:0] shm_done,
   input  logic [NUM_WARPS-1:0] dev_iss,
   input  logic [NUM_WARPS-1:0] dev_done,
   output logic [NUM_WARPS-1:0] runnable
);
   localparam int unsigned WC_W = $clog2(NUM_WARPS + 1);
   localparam int unsigned WSH  = $clog2(WARP_THREADS);
   localparam int unsigned NWW  = THREAD_CNT_W - WSH + 1;

   // elaboration-time parameter checks
   generate
      if (NUM_WARPS < 2 || NUM_WARPS > 32) begin : g_bad_warps
         $error("NUM_WARPS must lie in 2..32");
      end
      if (NUM_GROUPS < 1 || NUM_GROUPS > NUM_WARPS) begin : g_bad_groups
         $error("NUM_GROUPS must lie in 1..NUM_WARPS");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
   endgenerate

   bar_kind_t bar_k;
   assign bar_k = bar_kind_t'(bar_kind);

   // per-warp state
   logic [NUM_WARPS-1:0]            active;
   logic [NUM_WARPS-1:0]            waiting;
   logic [NUM_WARPS-1:0][GID_W-1:0] grp;
   bar_kind_t [NUM_WARPS-1:0]       wkind;
   logic [NUM_WARPS-1:0][CNT_W-1:0] shm_cnt;
   logic [NUM_WARPS-1:0][CNT_W-1:0] dev_cnt;
   logic [NUM_WARPS-1:0]            shm_full, dev_full;
   logic [NUM_WARPS-1:0]            disp_in;
   logic [NUM_WARPS-1:0]            release_w;

   // per-group derived conditions
   logic [NUM_GROUPS-1:0]            grp_shm_idle, grp_dev_idle;
   logic [NUM_GROUPS-1:0]            grp_arrive, grp_load, grp_go;
   logic [NUM_GROUPS-1:0][NUM_WARPS-1:0] member;

   logic [NWW-1:0] disp_nw;
   logic           bar_acc;

   // thread count rounded up to whole warps
   assign disp_nw = {1'b0, disp_threads[THREAD_CNT_W-1:WSH]}
                    + {{(NWW-1){1'b0}}, |disp_threads[WSH-1:0]};

   always_comb begin
      for (int w = 0; w < NUM_WARPS; w++) begin
         disp_in[w] = disp_valid && (w >= int'(disp_first))
                      && (w < int'(disp_first) + int'(disp_nw));
         runnable[w] = active[w] && !waiting[w] && !shm_full[w] && !dev_full[w];
      end
   end

   assign bar_acc = bar_valid && runnable[bar_warp];

   always_comb begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
         grp_shm_idle[g] = 1'b1;
         grp_dev_idle[g] = 1'b1;
         for (int w = 0; w < NUM_WARPS; w++) begin
            member[g][w] = active[w] && (grp[w] == GID_W'(g));
            if (member[g][w] && (shm_cnt[w] != '0)) grp_shm_idle[g] = 1'b0;
            if (member[g][w] && (dev_cnt[w] != '0)) grp_dev_idle[g] = 1'b0;
         end
         grp_load[g]   = disp_valid && (disp_group == GID_W'(g));
         grp_arrive[g] = bar_acc && bar_k.exec && (grp[bar_warp] == GID_W'(g));
      end
   end

   genvar gi, wi;
   generate
      for (gi = 0; gi < NUM_GROUPS; gi++) begin : g_grp
         wbs_group_sync #(.WC_W(WC_W)) u_sync (
            .clk         (clk),
            .rst_n       (rst_n),
            .load        (grp_load[gi]),
            .load_cnt    (WC_W'(disp_nw)),
            .arrive      (grp_arrive[gi]),
            .arrive_kind (bar_k),
            .shm_idle    (grp_shm_idle[gi]),
            .dev_idle    (grp_dev_idle[gi]),
            .go          (grp_go[gi])
         );
      end

      for (wi = 0; wi < NUM_WARPS; wi++) begin : g_warp
         wbs_op_counter #(.CNT_W(CNT_W)) u_shm (
            .clk (clk), .rst_n (rst_n), .clr (disp_in[wi]),
            .iss (shm_iss[wi]), .done (shm_done[wi]),
            .cnt (shm_cnt[wi]), .full (shm_full[wi])
         );
         wbs_op_counter #(.CNT_W(CNT_W)) u_dev (
            .clk (clk), .rst_n (rst_n), .clr (disp_in[wi]),
            .iss (dev_iss[wi]), .done (dev_done[wi]),
            .cnt (dev_cnt[wi]), .full (dev_full[wi])
         );

         // execution waiters follow the group decision; memory-only waiters
         // test their own components against the group idle flags
         always_comb begin
            if (wkind[wi].exec)
               release_w[wi] = waiting[wi] && grp_go[grp[wi]];
            else
               release_w[wi] = waiting[wi]
                  && (!wkind[wi].shm || grp_shm_idle[grp[wi]])
                  && (!wkind[wi].dev || grp_dev_idle[grp[wi]]);
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               active[wi]  <= 1'b0;
               waiting[wi] <= 1'b0;
               grp[wi]     <= '0;
               wkind[wi]   <= '0;
            end else if (disp_in[wi]) begin
               active[wi]  <= 1'b1;
               waiting[wi] <= 1'b0;
               grp[wi]     <= disp_group;
               wkind[wi]   <= '0;
            end else if (bar_acc && (bar_warp == WID_W'(wi))) begin
               waiting[wi] <= 1'b1;
               wkind[wi]   <= bar_k;
            end else if (release_w[wi]) begin
               waiting[wi] <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/wbs_checker.sv
module wbs_checker #(
   parameter int unsigned NUM_WARPS = 8,
   parameter int unsigned CNT_W     = 6,
   parameter int unsigned WID_W     = 3
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            disp_valid,
   input logic                            bar_valid,
   input logic [WID_W-1:0]                bar_warp,
   input logic [NUM_WARPS-1:0]            runnable,
   input logic [NUM_WARPS-1:0]            shm_iss,
   input logic [NUM_WARPS-1:0]            shm_done,
   input logic [NUM_WARPS-1:0]            dev_iss,
   input logic [NUM_WARPS-1:0]            dev_done,
   input logic [NUM_WARPS-1:0][CNT_W-1:0] shm_cnt,
   input logic [NUM_WARPS-1:0][CNT_W-1:0] dev_cnt
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   // R2: an accepted barrier parks its warp on the following cycle
   assert_park_on_barrier_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bar_valid && runnable[bar_warp] && !disp_valid) |=> !runnable[$past(bar_warp)]);

   genvar w;
   generate
      for (w = 0; w < NUM_WARPS; w++) begin : g_chk
         // R10: a counter at its ceiling never wraps to zero
         assert_no_overflow_shm_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (shm_cnt[w] == CMAX && !disp_valid) |=> (shm_cnt[w] != '0));
         assert_no_overflow_dev_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (dev_cnt[w] == CMAX && !disp_valid) |=> (dev_cnt[w] != '0));
         // R9: issue paired with completion keeps the count
         assert_pair_stable_shm_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (shm_iss[w] && shm_done[w] && !disp_valid) |=> $stable(shm_cnt[w]));
         assert_pair_stable_dev_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (dev_iss[w] && dev_done[w] && !disp_valid) |=> $stable(dev_cnt[w]));
      end
   endgenerate
endmodule

bind warp_barrier_sched wbs_checker #(
   .NUM_WARPS (NUM_WARPS),
   .CNT_W     (CNT_W),
   .WID_W     (WID_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .disp_valid (disp_valid),
   .bar_valid  (bar_valid),
   .bar_warp   (bar_warp),
   .runnable   (runnable),
   .shm_iss    (shm_iss),
   .shm_done   (shm_done),
   .dev_iss    (dev_iss),
   .dev_done   (dev_done),
   .shm_cnt    (shm_cnt),
   .dev_cnt    (dev_cnt)
);

// File: tb/sim_warp_barrier_sched.sv
`timescale 1ns/1ps
module sim_warp_barrier_sched;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        disp_valid = 1'b0;
   logic [0:0]  disp_group = '0;
   logic [2:0]  disp_first = '0;
   logic [10:0] disp_threads = '0;
   logic        bar_valid = 1'b0;
   logic [2:0]  bar_warp = '0;
   logic [2:0]  bar_kind = '0;
   logic [7:0]  shm_iss = '0, shm_done = '0, dev_iss = '0, dev_done = '0;
   logic [7:0]  runnable;

   int nchk = 0;
   int nbad = 0;
   bit finished = 0;

   logic [7:0] qm[$];
   string      qt[$];
   logic [7:0] em;
   string      et;

   localparam logic [2:0] K_EXEC = 3'b001, K_SHM = 3'b010, K_DEV = 3'b100;

   always #5 clk = ~clk;

   warp_barrier_sched u0 (
      .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_group(disp_group),
      .disp_first(disp_first), .disp_threads(disp_threads), .bar_valid(bar_valid),
      .bar_warp(bar_warp), .bar_kind(bar_kind), .shm_iss(shm_iss), .shm_done(shm_done),
      .dev_iss(dev_iss), .dev_done(dev_done), .runnable(runnable)
   );

   // monitor: compare the mask produced by each edge against the scoreboard
   always @(posedge clk) begin
      #2;
      if (qm.size() > 0) begin
         em = qm.pop_front();
         et = qt.pop_front();
         nchk++;
         if (runnable !== em) begin
            nbad++;
            $display("FAIL %s runnable=%h expected=%h", et, runnable, em);
         end
      end
   end

   // driver: inputs are set at a falling edge, expectation queued for the next rise
   task automatic step(input logic [7:0] m, input string t);
      qm.push_back(m);
      qt.push_back(t);
      @(posedge clk);
      @(negedge clk);
      disp_valid = 1'b0; bar_valid = 1'b0;
      shm_iss = '0; shm_done = '0; dev_iss = '0; dev_done = '0;
   endtask

   task automatic bar(input logic [2:0] w, input logic [2:0] k, input logic [7:0] m,
                      input string t);
      bar_valid = 1'b1; bar_warp = w; bar_kind = k;
      step(m, t);
   endtask

   task automatic disp(input logic g, input logic [2:0] f, input logic [10:0] n,
                       input logic [7:0] m, input string t);
      disp_valid = 1'b1; disp_group = g; disp_first = f; disp_threads = n;
      step(m, t);
   endtask

   task automatic group0_round(input logic [2:0] k, input string t);
      bar(3'd0, k, 8'h1E, t);
      bar(3'd1, k, 8'h1C, t);
      bar(3'd2, k, 8'h18, t);
      bar(3'd3, k, 8'h10, t);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step(8'h00, "R1 reset mask");
      disp(1'b0, 3'd0, 11'd100, 8'h0F, "R1 100 threads -> 4 warps");
      disp(1'b1, 3'd4, 11'd20,  8'h1F, "R1 20 threads -> 1 warp");

      // R3: four-warp execution barrier
      group0_round(K_EXEC, "R3 arrival");
      step(8'h1F, "R3 release together");

      // R4: single-warp group
      bar(3'd4, K_EXEC, 8'h0F, "R4 single warp parked");
      step(8'h1F, "R4 single warp back");

      // R5: immediate reuse
      group0_round(K_EXEC, "R5 reuse arrival");
      step(8'h1F, "R5 reuse release");

      // R6: shared barrier, other group's pending op must not matter
      shm_iss = 8'h12;
      step(8'h1F, "R6 shm issue");
      bar(3'd0, K_SHM, 8'h1E, "R6 shm barrier parked");
      step(8'h1E, "R6 still pending");
      step(8'h1E, "R6 still pending");
      shm_done = 8'h02;
      step(8'h1E, "R6 completion edge");
      step(8'h1F, "R6 released");
      shm_done = 8'h10;
      step(8'h1F, "R6 drain group 1");

      // R11: a shared-only barrier left no arrival behind
      group0_round(K_EXEC, "R11 arrival");
      step(8'h1F, "R11 release");

      // R7: device barrier waits on an atomic, ignores shared op
      shm_iss = 8'h01; dev_iss = 8'h04;
      step(8'h1F, "R7 issue");
      bar(3'd3, K_DEV, 8'h17, "R7 dev barrier parked");
      step(8'h17, "R7 atomic pending");
      dev_done = 8'h04;
      step(8'h17, "R7 completion edge");
      step(8'h1F, "R7 released with shm pending");
      shm_done = 8'h01;
      step(8'h1F, "R7 drain shm");

      // R8: combined execution + device
      dev_iss = 8'h02;
      step(8'h1F, "R8 dev issue");
      group0_round(K_EXEC | K_DEV, "R8 arrival");
      step(8'h10, "R8 held by device op");
      dev_done = 8'h02;
      step(8'h10, "R8 completion edge");
      step(8'h1F, "R8 released");

      // R9: paired issue and completion
      dev_iss = 8'h04;
      step(8'h1F, "R9 issue");
      dev_iss = 8'h04; dev_done = 8'h04;
      step(8'h1F, "R9 pair");
      dev_done = 8'h04;
      step(8'h1F, "R9 last completion");
      bar(3'd0, K_DEV, 8'h1E, "R9 dev barrier parked");
      step(8'h1F, "R9 counter back at zero");

      // R10: saturation of warp 4's shared counter
      for (int i = 0; i < 62; i++) begin
         shm_iss = 8'h10;
         step(8'h1F, "R10 filling");
      end
      shm_iss = 8'h10;
      step(8'h0F, "R10 at ceiling");
      shm_iss = 8'h10;
      step(8'h0F, "R10 issue dropped");
      shm_done = 8'h10;
      step(8'h1F, "R10 below ceiling");
      for (int i = 0; i < 62; i++) begin
         shm_done = 8'h10;
         step(8'h1F, "R10 draining");
      end
      bar(3'd4, K_SHM, 8'h0F, "R10 shm barrier parked");
      step(8'h1F, "R10 no wrap, counter empty");

      @(posedge clk);
      #5;
      finished = 1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         nchk++;
         nbad++;
         $display("FAIL watchdog runnable=%h expected=completion", runnable);
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end
endmodule